// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Tile

This block is the arithmetic tile of a programmable logic fabric. Each enabled clock it takes two 18-bit operands, forms their 36-bit product and either passes that product to a 48-bit result register or adds it to the running sum held there. Signed and unsigned products are both supported. The sum wraps on overflow.

The tile's behaviour is set by a 16-bit configuration word. The word is loaded through a serial chain that enters on one pin and leaves on another, so that many tiles can be daisy-chained. The word switches the two optional pipeline stages on or off (one after the operand inputs, one after the multiplier), selects accumulate or plain multiply, and selects signed or unsigned arithmetic. The only flow control is the clock enable: while it is low, every data register in the tile holds its value. The tile has no valid/ready handshake, so a source upstream must stall by lowering the enable.

A clear input travels through the pipeline with the operand pair it was presented with. It marks that pair as the first term of a new sum.

Top module: `mac_tile`

## Requirements
- R1: While rst_n is low, the result register, every pipeline register and the configuration word are zero. After release, mac_out reads 0 and cfg_dout reads 0.
- R2: On each clock with cfg_en high, the configuration word shifts one place toward bit 0, cfg_din enters at bit 15, and cfg_dout always shows bit 0. A word is therefore loaded least significant bit first in 16 shifts, and the word it replaces leaves on cfg_dout in the same order. With cfg_en low the word and cfg_dout hold.
- R3: Configuration bit 0 inserts an operand register and bit 1 inserts a product register. Operands captured at an enabled edge reach mac_out after 1 + bit0 + bit1 enabled edges, counting the capturing edge. With bits 2..0 all zero and a zero operand, mac_out is 0 one edge later.
- R4: Configuration bit 3 set treats both operands as two's complement and sign-extends the product to 48 bits. With bit 3 clear, the operands are unsigned and the product is zero-extended.
- R5: With configuration bit 2 set, each product that arrives adds to the result register modulo 2^48. With bit 2 clear, the arriving product replaces the register.
- R6: clr is delayed along with its operand pair. When that pair's product arrives in accumulate mode, the register is loaded with the product and the earlier sum is discarded.
- R7: While ce is low, no pipeline register or result register changes, so mac_out is stable. Operation resumes without losing or repeating any term.
- R8: Configuration bits 15..4 are reserved and have no effect on results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for every data register |
| clr | input | 1 | Start a new sum with this operand pair |
| a | input | 18 | Operand A |
| b | input | 18 | Operand B |
| mac_out | output | 48 | Result register |
| cfg_en | input | 1 | Shift the configuration chain |
| cfg_din | input | 1 | Serial configuration in |
| cfg_dout | output | 1 | Serial configuration out (bit 0 of the word) |

## Verification
An operand pair captured at an enabled edge reaches mac_out after 1 + bit0 + bit1 enabled edges. Disabled edges add delay but do not count toward that number. The bench records every enabled operand pair in a queue. After each enabled edge it retires the entry that lies bit0 + bit1 places behind the newest one, and it samples mac_out on the following falling edge. Edges with ce low leave the expected value unchanged, and mac_out is still compared on those edges. Results that would come from pipeline contents left over from before a configuration change are not compared. The configuration output is compared on the falling edge before each shift, where it must still show the old word's next bit.

// File: rtl/mac_tile_pkg.sv
`timescale 1ns/1ps
package mac_tile_pkg;
  localparam int OP_W  = 18;
  localparam int ACC_W = 48;
  localparam int CFG_W = 16;

  // Field order sets bit positions: the last field is bit 0.
  typedef struct packed {
    logic [CFG_W-5:0] rsvd;
    logic             sgn;       // bit 3: signed arithmetic
    logic             acc;       // bit 2: accumulate
    logic             prod_reg;  // bit 1: product register present
    logic             in_reg;    // bit 0: operand register present
  } cfg_t;
endpackage

// File: rtl/mac_cfg_chain.sv
`timescale 1ns/1ps
module mac_cfg_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic         dout,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (shift) word <= {din, word[W-1:1]};
  end

  assign dout = word[0];
endmodule

// File: rtl/mac_bypass_reg.sv
`timescale 1ns/1ps
module mac_bypass_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         use_reg,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  r <= '0;
    else if (ce) r <= d;
  end

  assign q = use_reg ? r : d;
endmodule

// File: rtl/mac_accum.sv
`timescale 1ns/1ps
module mac_accum #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         acc_en,
  input  logic         load,
  input  logic [W-1:0] p,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc <= '0;
    else if (ce)
      acc <= (acc_en && !load) ? acc + p : p;
  end
endmodule

// File: rtl/mac_tile.sv
`timescale 1ns/1ps
module mac_tile
  import mac_tile_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int ACCW = ACC_W,
  parameter int CFGW = CFG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            clr,
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  output logic [ACCW-1:0] mac_out,
  input  logic            cfg_en,
  input  logic            cfg_din,
  output logic            cfg_dout
);
  localparam int EXT  = OPW + 1;
  localparam int PW   = 2 * EXT;
  localparam int IN_W = 2 * OPW + 1;
  localparam int PR_W = ACCW + 1;

  logic [CFGW-1:0] cfg_word;
  cfg_t            cfg;
  logic            cfg_unused;

  mac_cfg_chain #(.W(CFGW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .shift(cfg_en),
    .din(cfg_din), .dout(cfg_dout), .word(cfg_word)
  );

  assign cfg        = cfg_t'(cfg_word);
  assign cfg_unused = ^cfg.rsvd;

  // Stage 1: optional operand register, clr travels along
  logic [IN_W-1:0] in_q;
  logic [OPW-1:0]  a1, b1;
  logic            clr1;

  mac_bypass_reg #(.W(IN_W)) u_in_stage (
    .clk(clk), .rst_n(rst_n), .ce(ce), .use_reg(cfg.in_reg),
    .d({clr, a, b}), .q(in_q)
  );
  assign {clr1, a1, b1} = in_q;

  // Multiplier: one extra top bit makes signed and unsigned share a path
  logic signed [EXT-1:0] ax, bx;
  logic signed [PW-1:0]  prod;
  logic [ACCW-1:0]       pext;

  assign ax   = {cfg.sgn & a1[OPW-1], a1};
  assign bx   = {cfg.sgn & b1[OPW-1], b1};
  assign prod = ax * bx;

  generate
    if (ACCW > PW) begin : g_ext
      assign pext = {{(ACCW-PW){prod[PW-1]}}, prod};
    end else begin : g_trunc
      assign pext = prod[ACCW-1:0];
    end
  endgenerate

  // Stage 2: optional product register
  logic [PR_W-1:0] pr_q;
  logic [ACCW-1:0] p2;
  logic            clr2;

  mac_bypass_reg #(.W(PR_W)) u_prod_stage (
    .clk(clk), .rst_n(rst_n), .ce(ce), .use_reg(cfg.prod_reg),
    .d({clr1, pext}), .q(pr_q)
  );
  assign {clr2, p2} = pr_q;

  // Result register
  mac_accum #(.W(ACCW)) u_acc (
    .clk(clk), .rst_n(rst_n), .ce(ce), .acc_en(cfg.acc),
    .load(clr2), .p(p2), .acc(mac_out)
  );
endmodule

// File: rtl/mac_tile_chk.sv
`timescale 1ns/1ps
module mac_tile_chk #(
  parameter int OPW  = 18,
  parameter int ACCW = 48,
  parameter int CFGW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce,
  input logic [OPW-1:0]  a,
  input logic [OPW-1:0]  b,
  input logic [ACCW-1:0] mac_out,
  input logic            cfg_en,
  input logic            cfg_din,
  input logic            cfg_dout,
  input logic [CFGW-1:0] cfg_word
);
  // R1: the first edge after release sees a cleared result
  a_r1_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> mac_out == '0);

  // R2: a new bit enters at the top
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_word[CFGW-1] == $past(cfg_din));

  // R2: the chain output holds when not shifting
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_dout));

  // R3: zero-latency plain mode gives a zero result one edge after a zero operand
  a_r3_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !cfg_en && cfg_word[2:0] == 3'b000 && (a == '0 || b == '0))
      |=> mac_out == '0);

  // R7: disabled edges leave the result untouched
  a_r7_ce_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(mac_out));
endmodule

bind mac_tile mac_tile_chk #(.OPW(OPW), .ACCW(ACCW), .CFGW(CFGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .a(a), .b(b), .mac_out(mac_out),
  .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout), .cfg_word(cfg_word)
);

// File: tb/mac_tile_bench.sv
`timescale 1ns/1ps
module mac_tile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic        clr = 1'b0;
  logic [17:0] a = '0;
  logic [17:0] b = '0;
  logic [47:0] mac_out;
  logic        cfg_en = 1'b0;
  logic        cfg_din = 1'b0;
  logic        cfg_dout;

  int          checks = 0;
  int          errors = 0;
  logic [15:0] cur_cfg = '0;

  always #5 clk = ~clk;

  mac_tile u_mac_tile (
    .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .a(a), .b(b),
    .mac_out(mac_out), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout)
  );

  function automatic logic [47:0] ref_prod(logic [17:0] x, logic [17:0] y, bit sg);
    logic [47:0] xe, ye;
    xe = sg ? {{30{x[17]}}, x} : {30'b0, x};
    ye = sg ? {{30{y[17]}}, y} : {30'b0, y};
    return xe * ye;
  endfunction

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // R2: shift a word in LSB first, checking the old word leaves in order
  task automatic load_cfg(logic [15:0] nw);
    for (int i = 0; i < 16; i++) begin
      check("R2", {47'b0, cfg_dout}, {47'b0, cur_cfg[i]});
      cfg_en  = 1'b1;
      cfg_din = nw[i];
      @(posedge clk);
      @(negedge clk);
    end
    cfg_en  = 1'b0;
    cur_cfg = nw;
  endtask

  task automatic run(logic [15:0] c, int n, bit maxops, string tg);
    logic [36:0] hist[$];
    logic [36:0] e;
    logic [47:0] expv;
    logic [47:0] p;
    bit          valid;
    bit          ce_v, clr_v;
    logic [17:0] a_v, b_v;
    int          d, k;
    string       tag;
    load_cfg(c);
    d = int'(c[0]) + int'(c[1]);
    k = 0;
    valid = 0;
    expv = '0;
    for (int step = 0; step < n; step++) begin
      ce_v  = maxops || step == 0 || ($urandom % 5) != 0;
      clr_v = (step == 0) || (!maxops && ($urandom % 16) == 0);
      a_v   = maxops ? 18'h3FFFF : 18'($urandom);
      b_v   = maxops ? 18'h3FFFF : 18'($urandom);
      ce = ce_v; clr = clr_v; a = a_v; b = b_v;
      tag = "R7";
      @(posedge clk);
      if (ce_v) begin
        hist.push_back({clr_v, a_v, b_v});
        if (k >= d) begin
          e = hist[k-d];
          p = ref_prod(e[35:18], e[17:0], c[3]);
          expv = (c[2] && !e[36]) ? expv + p : p;
          valid = 1;
          if (c[2] && e[36]) tag = "R6";
          else if (c[2])     tag = "R5";
          else if (c[3])     tag = "R4";
          else               tag = "R3";
        end
        k++;
      end
      if (tg != "") tag = tg;
      @(negedge clk);
      if (valid) check(tag, mac_out, expv);
    end
    ce = 1'b0;
    clr = 1'b0;
  endtask

  task automatic direct(logic [17:0] x, logic [17:0] y, logic [47:0] expv);
    ce = 1'b1; clr = 1'b0; a = x; b = y;
    @(posedge clk);
    @(negedge clk);
    check("R4", mac_out, expv);
    ce = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", mac_out, 48'h0);
    check("R1", {47'b0, cfg_dout}, 48'h0);

    // every combination of the four defined bits
    for (int c = 0; c < 16; c++) run(16'(c), 300, 1'b0, "");

    // reserved bits set
    run(16'hA5F0 | 16'h0007, 300, 1'b0, "R8");
    run(16'hFFF0 | 16'h000E, 300, 1'b0, "R8");

    // directed extremes at zero latency, plain multiply
    load_cfg(16'h0008);
    direct(18'h20000, 18'h20000, 48'h0004_0000_0000);
    direct(18'h20000, 18'h1FFFF, 48'hFFFC_0002_0000);
    direct(18'h3FFFF, 18'h3FFFF, 48'h0000_0000_0001);
    load_cfg(16'h0000);
    direct(18'h3FFFF, 18'h3FFFF, 48'h000F_FFF8_0001);

    // R5: long unsigned accumulation past 2^48
    run(16'h0004, 5000, 1'b1, "R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule